// File: doc/BRIEF.md
# Random-Access Scan Register File

This block is a bank of state flip-flops that serves two purposes. In functional mode every element loads its bit of the next-state vector on each clock and drives its bit of the present-state vector, as a plain register would. Under test, any single element can be picked through an address decoder, in the way a memory word is picked. It can then be overwritten from a one-bit test data input, and its value can be read back on a one-bit test output.

Test access is random, not serial. A tester can therefore change only the bits that differ between two consecutive patterns, and it can read just the bits it cares about. The readout path sits beside the functional path and does not load it. As a result, the bit at the applied address can be watched on the test output while the surrounding logic keeps running normally.

Each element takes one of four operations per clock. The operations come from a package enumeration, listed here in priority order:
- CLEAR: synchronous reset.
- FORCE: test write to this element's address.
- HOLD: global hold is asserted.
- LOAD: take the functional next state.

Top module: `rascan_regfile`

## Requirements
- R1: While `rst` is high at a rising clock edge, every element and `tst_dout` become 0 at that edge, whatever the other inputs are.
- R2: When `tst_we` is high at an edge and `tst_addr` holds a value below NUM_BITS, the element with index `tst_addr` (bit `tst_addr` of `func_q`) takes `tst_din` at that edge, and no other element is written.
- R3: With `tst_we` low and `hold` low, each bit of `func_q` equals the corresponding bit of `func_d` sampled at the previous edge.
- R4: With `hold` high, every element that is not being written keeps its value. A test write to an in-range address still takes effect while `hold` is high.
- R5: `tst_dout` is registered. After an edge it equals bit `tst_addr` of `func_q` as it stood just before that edge, so a read has one cycle of latency.
- R6: Reading does not disturb the functional path. While elements keep loading `func_d`, `tst_dout` shows the observed bit one cycle late, and `func_q` is unaffected.
- R7: An address of NUM_BITS or above writes no element and makes `tst_dout` read 0 after the next edge.
- R8: Test writes may target addresses in any order. With `hold` high, each write changes only its own bit, so the bank ends up as the sequence of single-bit updates implies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Global hold: unaddressed elements keep their value |
| func_d | input | NUM_BITS | Functional next-state vector |
| func_q | output | NUM_BITS | Present-state vector |
| tst_addr | input | ADDR_W | Element address for test write and readout |
| tst_we | input | 1 | Test write enable for the addressed element |
| tst_din | input | 1 | Test data written into the addressed element |
| tst_dout | output | 1 | Registered value of the addressed element |

## Verification
Every result in this block is due exactly one edge after its stimulus:
- Loads, holds, forced writes and resets appear on `func_q` right after the edge at which the inputs were applied.
- `tst_dout` after an edge reports the element as it was before that edge. A read issued in the same cycle as a state change therefore returns the old bit, and the new bit appears one edge later.

The bench drives inputs just after an edge and samples one time unit after the following edge. For the readout it predicts the pre-edge state, which is how the one-cycle lag of R5 and R6 is pinned down, including the case where the functional path flips the observed bit in the same cycle.

// File: rtl/rascan_pkg.sv
package rascan_pkg;

    // Per-element operation chosen each clock, highest priority first.
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_FORCE = 2'd1,
        OP_HOLD  = 2'd2,
        OP_LOAD  = 2'd3
    } cell_op_e;

    function automatic cell_op_e pick_op(input logic rst,
                                         input logic force_wr,
                                         input logic hold);
        if (rst)           return OP_CLEAR;
        else if (force_wr) return OP_FORCE;
        else if (hold)     return OP_HOLD;
        else               return OP_LOAD;
    endfunction

endpackage

// File: rtl/rascan_decoder.sv
module rascan_decoder #(
    parameter int NUM_BITS = 12,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_BITS-1:0] sel
);

    // One comparator per element; out-of-range addresses match nothing.
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_dec
        assign sel[i] = (addr == ADDR_W'(i));
    end

    // R2: never more than one element selected.
    a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R7: an address at or beyond the bank selects no element.
    a_r7_no_select: assert property (@(posedge clk) disable iff (rst)
        (int'(addr) >= NUM_BITS) |-> (sel == '0));

endmodule

// File: rtl/rascan_cell.sv
module rascan_cell
    import rascan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic sel,
    input  logic we,
    input  logic din,
    input  logic d,
    output logic q
);

    cell_op_e op;

    always_comb begin
        op = pick_op(rst, we && sel, hold);
    end

    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR: q <= 1'b0;
            OP_FORCE: q <= din;
            OP_HOLD:  q <= q;
            OP_LOAD:  q <= d;
            default:  q <= 1'b0;
        endcase
    end

    // R2: a selected write lands on the next edge.
    a_r2_force: assert property (@(posedge clk) disable iff (rst)
        (we && sel) |=> (q == $past(din)));

    // R3: with no write and no hold the element follows its next state.
    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        (!(we && sel) && !hold) |=> (q == $past(d)));

    // R4: with hold and no write the element keeps its value.
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!(we && sel) && hold) |=> $stable(q));

endmodule

// File: rtl/rascan_readout.sv
module rascan_readout #(
    parameter int NUM_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_BITS-1:0] state,
    input  logic [NUM_BITS-1:0] sel,
    output logic                dout
);

    logic picked;

    // AND-OR selection reuses the decoder; no select -> 0.
    always_comb begin
        picked = |(state & sel);
    end

    always_ff @(posedge clk) begin
        if (rst) dout <= 1'b0;
        else     dout <= picked;
    end

    // R7: no selection yields a zero readout one cycle later.
    a_r7_zero_read: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |=> (dout == 1'b0));

endmodule

// File: rtl/rascan_regfile.sv
module rascan_regfile #(
    parameter  int NUM_BITS = 12,
    localparam int ADDR_W   = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold,
    input  logic [NUM_BITS-1:0] func_d,
    output logic [NUM_BITS-1:0] func_q,
    input  logic [ADDR_W-1:0]   tst_addr,
    input  logic                tst_we,
    input  logic                tst_din,
    output logic                tst_dout
);

    logic [NUM_BITS-1:0] sel;

    rascan_decoder #(
        .NUM_BITS (NUM_BITS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .clk  (clk),
        .rst  (rst),
        .addr (tst_addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
        rascan_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .hold (hold),
            .sel  (sel[i]),
            .we   (tst_we),
            .din  (tst_din),
            .d    (func_d[i]),
            .q    (func_q[i])
        );
    end

    rascan_readout #(
        .NUM_BITS (NUM_BITS)
    ) u_rd (
        .clk   (clk),
        .rst   (rst),
        .state (func_q),
        .sel   (sel),
        .dout  (tst_dout)
    );

    // Independent view of the addressed bit for the latency check.
    logic [NUM_BITS-1:0] shifted_q;
    always_comb begin
        shifted_q = func_q >> tst_addr;
    end

    // R1: reset clears the bank and the readout.
    a_r1_reset: assert property (@(posedge clk)
        rst |=> ((func_q == '0) && (tst_dout == 1'b0)));

    // R5: readout is the pre-edge addressed bit, one cycle late.
    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tst_dout == $past(shifted_q[0])));

    // R7: out-of-range write leaves the bank to its non-test behaviour.
    a_r7_no_write: assert property (@(posedge clk) disable iff (rst)
        (tst_we && (int'(tst_addr) >= NUM_BITS) && hold) |=> $stable(func_q));

endmodule

// File: tb/rascan_regfile_tb.sv
module rascan_regfile_tb;

    localparam int NB = 12;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          hold;
    logic [NB-1:0] func_d;
    logic [NB-1:0] func_q;
    logic [AW-1:0] tst_addr;
    logic          tst_we;
    logic          tst_din;
    logic          tst_dout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rascan_regfile #(.NUM_BITS(NB)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .func_d   (func_d),
        .func_q   (func_q),
        .tst_addr (tst_addr),
        .tst_we   (tst_we),
        .tst_din  (tst_din),
        .tst_dout (tst_dout)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; hold = 1'b0; func_d = '1;
        tst_we = 1'b1; tst_addr = 4'd0; tst_din = 1'b1;
        tick();
        check(func_q == '0, "R1 bank", 32'(func_q), 0);
        check(tst_dout == 1'b0, "R1 dout", 32'(tst_dout), 0);
        rst = 1'b0; tst_we = 1'b0;
    endtask

    task automatic t_functional();
        logic [NB-1:0] pats [3] = '{12'hA5C, 12'h3F0, 12'hFFF};
        hold = 1'b0; tst_we = 1'b0;
        for (int i = 0; i < 3; i++) begin
            func_d = pats[i];
            tick();
            check(func_q == pats[i], "R3 load", 32'(func_q), 32'(pats[i]));
        end
    endtask

    task automatic t_hold();
        hold = 1'b0; func_d = 12'h3F0;
        tick();
        hold = 1'b1; func_d = 12'h00F;
        tick();
        check(func_q == 12'h3F0, "R4 hold", 32'(func_q), 32'h3F0);
    endtask

    task automatic t_force();
        hold = 1'b0; func_d = '0;
        tst_we = 1'b1; tst_addr = 4'd5; tst_din = 1'b1;
        tick();
        check(func_q == 12'h020, "R2 set one", 32'(func_q), 32'h020);
        func_d = '1; tst_din = 1'b0;
        tick();
        check(func_q == 12'hFDF, "R2 clear one", 32'(func_q), 32'hFDF);
        hold = 1'b1; tst_din = 1'b1;
        tick();
        check(func_q == 12'hFFF, "R4 write under hold", 32'(func_q), 32'hFFF);
        tst_addr = 4'd0; tst_din = 1'b0;
        tick();
        check(func_q == 12'hFFE, "R4 write under hold", 32'(func_q), 32'hFFE);
        tst_we = 1'b0;
    endtask

    task automatic t_any_order();
        logic [AW-1:0] a [4] = '{4'd9, 4'd2, 4'd11, 4'd9};
        logic          v [4] = '{1'b0, 1'b0, 1'b0, 1'b1};
        logic [NB-1:0] e [4] = '{12'hDFE, 12'hDFA, 12'h5FA, 12'h7FA};
        hold = 1'b1; tst_we = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tst_addr = a[i]; tst_din = v[i];
            tick();
            check(func_q == e[i], "R8 order", 32'(func_q), 32'(e[i]));
        end
        tst_we = 1'b0;
    endtask

    task automatic t_readout();
        logic [NB-1:0] img = 12'h7FA;
        hold = 1'b1; tst_we = 1'b0;
        for (int i = 0; i < NB; i++) begin
            tst_addr = AW'(i);
            tick();
            check(tst_dout == img[i], "R5 read", 32'(tst_dout), 32'(img[i]));
        end
    endtask

    task automatic t_observe();
        hold = 1'b0; tst_we = 1'b0; func_d = 12'h0F0;
        tick();
        tst_addr = 4'd4; func_d = 12'h000;
        tick();
        check(tst_dout == 1'b1, "R6 old bit", 32'(tst_dout), 1);
        check(func_q == 12'h000, "R6 func", 32'(func_q), 0);
        tick();
        check(tst_dout == 1'b0, "R6 new bit", 32'(tst_dout), 0);
    endtask

    task automatic t_out_of_range();
        hold = 1'b0; tst_we = 1'b0; func_d = 12'h555;
        tst_addr = 4'd0;
        tick();
        hold = 1'b1; tst_we = 1'b1; tst_addr = 4'd13; tst_din = 1'b1;
        tick();
        check(func_q == 12'h555, "R7 no write", 32'(func_q), 32'h555);
        tst_we = 1'b0; tst_addr = 4'd14;
        tick();
        check(tst_dout == 1'b0, "R7 read zero", 32'(tst_dout), 0);
        tst_addr = 4'd15;
        tick();
        check(tst_dout == 1'b0, "R7 read zero", 32'(tst_dout), 0);
    endtask

    task automatic t_reset_mid();
        tst_addr = 4'd0;
        tick();
        rst = 1'b1; hold = 1'b0; func_d = '1;
        tick();
        check(func_q == '0, "R1 mid-run", 32'(func_q), 0);
        check(tst_dout == 1'b0, "R1 mid-run dout", 32'(tst_dout), 0);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; hold = 1'b0; func_d = '0;
        tst_addr = '0; tst_we = 1'b0; tst_din = 1'b0;
        tick();
        t_reset();
        t_functional();
        t_hold();
        t_force();
        t_any_order();
        t_readout();
        t_observe();
        t_out_of_range();
        t_reset_mid();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule